// File: doc/BRIEF.md
# Multi-Core Interrupt Routing Controller

This block collects a set of level-sensitive interrupt lines and steers them onto a grid of output lines, one for every pairing of a processor core with one of that core's interrupt pin indices. Each source owns an 8-bit routing entry. The low nibble names the cores that source may reach, and the high nibble names the pin indices. A global enable mask gates every source. Software sets bits in this mask through one register and clears them through another, so no read-modify-write sequence is needed.

Outputs are recomputed combinationally from the live input levels, the enable mask and the routing entries. Nothing is latched, so an output falls as soon as its sources fall or are masked. Output (c, i) is asserted when core c has at least one routed pending source and pin i has at least one routed pending source. These two tests are made independently. Two sources routed to different (core, pin) pairs can therefore raise the crossed outputs as well.

Software reaches the block through a plain register port carrying an address, a byte count, a write strobe and write data. Writes take effect at the clock edge. Read data follows the address combinationally. The port has no handshake, because every access completes in the cycle it is presented.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every routing entry and the enable mask are zero, and all outputs are low even with every input high.
- R2: A 4-byte read at offset 0x20 returns the global status, which is the current input levels ANDed with the enable mask (bit n = source n).
- R3: A 1-byte write at offset n (n below 32) stores wdata[7:0] as the routing entry of source n, and a 1-byte read there returns it in rdata[7:0] with the upper bits zero. Entry bits 3:0 select cores 0 to 3, and bits 7:4 select pins 0 to 3.
- R4: A 4-byte write at 0x28 sets every enable bit that is 1 in the data and leaves the others unchanged. A 4-byte read at 0x24 returns the mask.
- R5: A 4-byte write at 0x2C clears every enable bit that is 1 in the data, and the affected outputs drop.
- R6: A 4-byte read at 0x40 + 8·c returns the pending, enabled sources whose entry has core bit c set.
- R7: Output 4·c + i is high exactly when some pending, enabled source has core bit c set and some (possibly different) pending, enabled source has pin bit 4+i set.
- R8: Outputs and status follow input levels with no latching: an input dropping low clears its contribution in the same cycle.
- R9: An access with a byte count other than 1 or 4 is ignored on write and reads zero. So is a 1-byte access at or above offset 0x20, a 4-byte access that is not 4-byte aligned, and a 4-byte access in the routing range.
- R10: Inside the per-core window, offsets that are not multiples of 8 read zero, and writes to a per-core status offset leave its value unchanged.
- R11: Offsets that map to nothing readable (including 0x28, 0x2C, 0x30 and 0x60 and above) read zero, and 4-byte writes to read-only offsets leave state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC (32) | Level interrupt inputs, bit n is source n |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_len | input | 3 | Access width in bytes (1 or 4 are valid) |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address and width |
| irq_out | output | N_CORE·N_PIN (16) | Routed outputs, index 4·core + pin |

## Verification
The bench builds the block with its default parameters: 32 sources, 4 cores and 4 pins with an 8-bit offset. This gives the full address map, including the top routing entry at 0x1F, the last per-core register at 0x58 and the gap offsets beside it. With these values a single source routed to every core and pin drives all 16 outputs at once. Two sources routed to separate pairs produce the crossed outputs that a per-source match would never raise.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DW          = 32;
  localparam int OFS_STAT    = 'h20;
  localparam int OFS_EN      = 'h24;
  localparam int OFS_SET     = 'h28;
  localparam int OFS_CLR     = 'h2C;
  localparam int OFS_CORE    = 'h40;
  localparam int CORE_STRIDE = 8;

  typedef struct packed {
    logic route;
    logic stat;
    logic en_rd;
    logic set;
    logic clr;
    logic core;
  } acc_hit_t;
endpackage

// File: rtl/irq_route_dec.sv
module irq_route_dec
  import irq_route_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [2:0]                 len,
  output acc_hit_t                   hit,
  output logic [$clog2(N_CORE)-1:0]  core_idx
);
  localparam int CW = $clog2(N_CORE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_CORE = ADDR_W'(OFS_CORE);
  localparam logic [ADDR_W-1:0] A_SPAN = ADDR_W'(CORE_STRIDE * N_CORE);
  localparam logic [ADDR_W-1:0] A_NSRC = ADDR_W'(N_SRC);

  logic              word_ok;
  logic [ADDR_W-1:0] offs;

  always_comb begin
    word_ok   = (len == 3'd4) && (addr[1:0] == 2'b00);
    offs      = addr - A_CORE;
    hit.route = (len == 3'd1) && (addr < A_NSRC);
    hit.stat  = word_ok && (addr == A_STAT);
    hit.en_rd = word_ok && (addr == A_EN);
    hit.set   = word_ok && (addr == A_SET);
    hit.clr   = word_ok && (addr == A_CLR);
    hit.core  = word_ok && (addr >= A_CORE) && (offs < A_SPAN) && (offs[2:0] == 3'b000);
    core_idx  = offs[CW+2:3];
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  acc_hit_t                   hit,
  input  logic [$clog2(N_SRC)-1:0]   idx,
  input  logic [DW-1:0]              wdata,
  output logic [N_SRC-1:0][7:0]      route_q,
  output logic [N_SRC-1:0]           en_q
);
  logic [N_SRC-1:0] wmask;
  assign wmask = wdata[N_SRC-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      en_q    <= '0;
    end else if (wr) begin
      if (hit.route) route_q[idx] <= wdata[7:0];
      if (hit.set)      en_q <= en_q | wmask;
      else if (hit.clr) en_q <= en_q & ~wmask;
    end
  end

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit.set) |=> ((en_q & $past(wmask)) == $past(wmask)));

  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit.clr) |=> ((en_q & $past(wmask)) == '0));

  // R9
  bad_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit.route && !hit.set && !hit.clr) |=> ($stable(en_q) && $stable(route_q)));
endmodule

// File: rtl/irq_route_fabric.sv
module irq_route_fabric #(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int N_PIN  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_SRC-1:0]              lvl,
  input  logic [N_SRC-1:0]              en,
  input  logic [N_SRC-1:0][7:0]         route,
  output logic [N_SRC-1:0]              glob,
  output logic [N_CORE-1:0][N_SRC-1:0]  core_stat,
  output logic [N_CORE*N_PIN-1:0]       irq_out
);
  logic [N_PIN-1:0][N_SRC-1:0] pin_stat;

  assign glob = lvl & en;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    for (genvar c = 0; c < N_CORE; c++) begin : g_core
      assign core_stat[c][s] = glob[s] & route[s][c];
    end
    for (genvar i = 0; i < N_PIN; i++) begin : g_pin
      assign pin_stat[i][s] = glob[s] & route[s][4+i];
    end
  end

  for (genvar c = 0; c < N_CORE; c++) begin : g_oc
    for (genvar i = 0; i < N_PIN; i++) begin : g_oi
      assign irq_out[c*N_PIN+i] = (|core_stat[c]) & (|pin_stat[i]);
    end
  end

  // R8
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl & en) == '0) |-> (irq_out == '0));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int N_CORE = 4,
  parameter int N_PIN  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        irq_in,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [2:0]              bus_len,
  input  logic                    bus_wr,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  output logic [N_CORE*N_PIN-1:0] irq_out
);
  localparam int SW = $clog2(N_SRC);
  localparam int CW = $clog2(N_CORE);

  acc_hit_t                   hit;
  logic [CW-1:0]              core_idx;
  logic [N_SRC-1:0][7:0]      route_q;
  logic [N_SRC-1:0]           en_q;
  logic [N_SRC-1:0]           glob;
  logic [N_CORE-1:0][N_SRC-1:0] core_stat;

  irq_route_dec #(.N_SRC(N_SRC), .N_CORE(N_CORE), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .len(bus_len), .hit(hit), .core_idx(core_idx)
  );

  irq_route_regs #(.N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .hit(hit),
    .idx(bus_addr[SW-1:0]), .wdata(bus_wdata),
    .route_q(route_q), .en_q(en_q)
  );

  irq_route_fabric #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_PIN(N_PIN)) u_fab (
    .clk(clk), .rst_n(rst_n), .lvl(irq_in), .en(en_q), .route(route_q),
    .glob(glob), .core_stat(core_stat), .irq_out(irq_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit.route)      bus_rdata = DW'(route_q[bus_addr[SW-1:0]]);
    else if (hit.stat)  bus_rdata = DW'(glob);
    else if (hit.en_rd) bus_rdata = DW'(en_q);
    else if (hit.core)  bus_rdata = DW'(core_stat[core_idx]);
  end

  // R10
  core_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_len == 3'd4) && (bus_addr >= ADDR_W'(OFS_CORE)) && (bus_addr[2:0] != 3'b000))
      |-> (bus_rdata == '0));
endmodule

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic [2:0]  bus_len = 3'd4;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_out;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_route_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_len(bus_len), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [2:0] l, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_len = l; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [2:0] l, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_len = l; bus_wr = 1'b0;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic out_is(string tag, logic [15:0] exp);
    @(negedge clk);
    #1;
    chk(tag, {16'h0, irq_out}, {16'h0, exp});
  endtask

  task automatic t_reset;
    irq_in = '1;
    out_is("R1 outputs low", 16'h0000);
    rd("R1 enable zero", 8'h24, 3'd4, 32'h0);
    rd("R1 route zero", 8'h05, 3'd1, 32'h0);
    rd("R1 status zero", 8'h20, 3'd4, 32'h0);
    irq_in = '0;
  endtask

  task automatic t_route;
    wr(8'h03, 3'd1, 32'h0000_005A);
    rd("R3 byte readback", 8'h03, 3'd1, 32'h5A);
    wr(8'h1F, 3'd1, 32'h0012_34A5);
    rd("R3 low byte only", 8'h1F, 3'd1, 32'hA5);
    wr(8'h03, 3'd2, 32'hFF);
    rd("R9 two-byte write ignored", 8'h03, 3'd1, 32'h5A);
    rd("R9 word read of route range", 8'h00, 3'd4, 32'h0);
    rd("R9 two-byte read", 8'h03, 3'd2, 32'h0);
    wr(8'h28, 3'd1, 32'hFF);
    rd("R9 byte write to set ignored", 8'h24, 3'd4, 32'h0);
  endtask

  task automatic t_enable;
    wr(8'h28, 3'd4, 32'h0000_00FF);
    rd("R4 set low byte", 8'h24, 3'd4, 32'h0000_00FF);
    wr(8'h28, 3'd4, 32'hF000_0000);
    rd("R4 set keeps others", 8'h24, 3'd4, 32'hF000_00FF);
    wr(8'h2C, 3'd4, 32'h0000_000F);
    rd("R5 clear bits", 8'h24, 3'd4, 32'hF000_00F0);
    wr(8'h2A, 3'd4, 32'hFFFF_FFFF);
    rd("R9 unaligned write ignored", 8'h24, 3'd4, 32'hF000_00F0);
    wr(8'h24, 3'd4, 32'h0000_FFFF);
    rd("R11 read-only write ignored", 8'h24, 3'd4, 32'hF000_00F0);
  endtask

  task automatic t_status;
    irq_in = 32'h1000_0031;
    rd("R2 global status", 8'h20, 3'd4, 32'h1000_0030);
    out_is("R7 unrouted pending", 16'h0000);
    irq_in = '0;
    wr(8'h03, 3'd1, 32'h0);
    wr(8'h1F, 3'd1, 32'h0);
    wr(8'h28, 3'd4, 32'hFFFF_FFFF);
  endtask

  task automatic t_single;
    wr(8'h00, 3'd1, 32'h42);
    irq_in = 32'h1;
    out_is("R7 core1 pin2", 16'h0040);
    rd("R6 core1 status", 8'h48, 3'd4, 32'h1);
    rd("R6 core0 status", 8'h40, 3'd4, 32'h0);
    irq_in = '0;
    out_is("R8 drop follows input", 16'h0000);
    rd("R8 status no latch", 8'h20, 3'd4, 32'h0);
  endtask

  task automatic t_cross;
    wr(8'h01, 3'd1, 32'h11);
    wr(8'h02, 3'd1, 32'h22);
    irq_in = 32'h6;
    out_is("R7 cross routing", 16'h0033);
    rd("R6 core0 cross", 8'h40, 3'd4, 32'h2);
    rd("R6 core1 cross", 8'h48, 3'd4, 32'h4);
    wr(8'h2C, 3'd4, 32'h4);
    out_is("R5 masked source drops", 16'h0001);
    wr(8'h28, 3'd4, 32'h4);
    irq_in = '0;
  endtask

  task automatic t_nopin;
    wr(8'h05, 3'd1, 32'h08);
    irq_in = 32'h20;
    out_is("R7 core without pin", 16'h0000);
    rd("R6 core3 status", 8'h58, 3'd4, 32'h20);
    wr(8'h58, 3'd4, 32'h0);
    rd("R10 core write no effect", 8'h58, 3'd4, 32'h20);
    rd("R10 stride gap 0x5C", 8'h5C, 3'd4, 32'h0);
    rd("R10 stride gap 0x44", 8'h44, 3'd4, 32'h0);
    irq_in = '0;
  endtask

  task automatic t_fanout;
    wr(8'h06, 3'd1, 32'hFF);
    irq_in = 32'h40;
    out_is("R7 full fan-out", 16'hFFFF);
    irq_in = '0;
    out_is("R8 fan-out drop", 16'h0000);
  endtask

  task automatic t_unmapped;
    rd("R11 offset 0x30", 8'h30, 3'd4, 32'h0);
    rd("R11 offset 0x60", 8'h60, 3'd4, 32'h0);
    rd("R11 clear reads zero", 8'h2C, 3'd4, 32'h0);
    rd("R11 set reads zero", 8'h28, 3'd4, 32'h0);
    rd("R9 byte read of status", 8'h20, 3'd1, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_route();
    t_enable();
    t_status();
    t_single();
    t_cross();
    t_nopin();
    t_fanout();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule